// File: doc/BRIEF.md
# Processor-Side Channel Access Adapter

This block sits on the processor side of a communication wrapper. It sees a simple processor bus (select, write flag, word address, write data, read data, ready) on one side. On the other side it masters an internal bus shared by several channel adapters. It decodes each processor address against per-channel windows and raises a single dedicated enable toward the channel that owns the window. It then runs a fixed-length transfer sequence that moves one word over the shared internal data lines. Processor ready is held off until that sequence has finished.

Each channel adapter signals newly arrived data on its own interrupt line. The block latches a rising edge on any line into a pending bit and drives one processor interrupt while any bit is set. A status address returns the pending channel with the highest configured level. Reading a channel's data clears that channel's pending bit. Addresses outside every window, and outside the status address, finish at once with no enable and read as zero.

Top module: `proc_wrap_adapter`

## Requirements
- R1: While reset is high and on the first cycle after it, cpu_ready, cpu_irq and every ib_en bit are 0 and cpu_rdata is 0.
- R2: An access whose word address lies in channel i's window [CH_BASE + i*2^OFFW, CH_BASE + (i+1)*2^OFFW) drives ib_en with only bit i set. It also drives ib_addr with the low OFFW address bits. Both start in the cycle after cpu_sel is first sampled, and ib_en returns to 0 in the cycle where cpu_ready is high.
- R3: At no time is more than one ib_en bit high.
- R4: A channel write raises cpu_ready in the 3rd cycle of the access, counting the cycle where cpu_sel is first sampled as the 1st. While enabled, ib_we is 1 and ib_wdata equals the processor write data.
- R5: A channel read raises cpu_ready in the 7th cycle of the access with ib_we at 0. cpu_rdata then holds the value the enabled channel drove on ib_rdata.
- R6: An access that matches no channel window and is not a status read asserts no ib_en bit. It raises cpu_ready in the 2nd cycle, and a read returns 0.
- R7: A 0-to-1 transition of ch_irq[i] sets pending bit i; a line held high does not set it again. cpu_irq is 1 in the cycle after the edge and stays 1 while any pending bit is set.
- R8: A read of STAT_ADDR completes in the 2nd cycle. It returns bit 31 = 1 and bits [1:0] = the index of the pending channel with the highest level from LEVELS (2 bits per channel, channel 0 in the low bits; the defaults are 1, 3, 0, 3 for channels 0 to 3). Equal levels go to the lower index. With no bit pending it returns 0.
- R9: A completed read of channel i clears pending bit i. A write to channel i leaves it set.
- R10: cpu_ready is high for exactly one cycle per access, and no new access begins in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel | input | 1 | Processor access request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Processor word address |
| cpu_wdata | input | DW | Processor write data |
| cpu_rdata | output | DW | Read data, valid with cpu_ready |
| cpu_ready | output | 1 | One-cycle access completion |
| cpu_irq | output | 1 | Any channel interrupt pending |
| ib_en | output | NCH | One-hot channel enable |
| ib_we | output | 1 | Internal bus write flag |
| ib_addr | output | OFFW | Offset inside the channel window |
| ib_wdata | output | DW | Internal bus write data |
| ib_rdata | input | DW | Data driven by the enabled channel |
| ch_irq | input | NCH | Per-channel data-arrival lines |

## Verification
Results are due at fixed distances from the cycle in which cpu_sel is first sampled. Enable and internal address appear one edge later. Ready and read data arrive after 1 edge for misses and status reads, 2 edges for channel writes and 6 edges for channel reads. Interrupt and pending changes show one edge after the line edge or the clearing read. The driver pushes the expected edge count and data for each access into a queue. A monitor samples just after every rising edge, counts edges while the request is held, and on ready pops and compares both. Interrupt and status expectations come from a priority model kept in the bench.

// File: rtl/pwa_pkg.sv
package pwa_pkg;
  typedef enum logic [1:0] {
    XF_IDLE = 2'd0,
    XF_BUSY = 2'd1,
    XF_DONE = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/pwa_decode.sv
module pwa_decode #(
  parameter int AW = 16,
  parameter int NCH = 4,
  parameter int OFFW = 4,
  parameter logic [AW-1:0] CH_BASE = 16'h0100,
  parameter logic [AW-1:0] STAT_ADDR = 16'h0200
) (
  input  logic [AW-1:0]  addr,
  output logic [NCH-1:0] hit,
  output logic           stat_hit
);
  localparam int SPAN = 1 << OFFW;

  for (genvar g = 0; g < NCH; g++) begin : g_win
    localparam logic [AW:0] LO = {1'b0, CH_BASE} + (AW+1)'(g * SPAN);
    localparam logic [AW:0] HI = LO + (AW+1)'(SPAN);
    assign hit[g] = ({1'b0, addr} >= LO) && ({1'b0, addr} < HI);
  end

  assign stat_hit = (addr == STAT_ADDR);
endmodule

// File: rtl/pwa_irq.sv
module pwa_irq #(
  parameter int NCH = 4,
  parameter int LW = 2,
  parameter logic [NCH*LW-1:0] LEVELS = 8'b11_00_11_01,
  parameter int IDW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] ch_irq,
  input  logic [NCH-1:0] clr_vec,
  output logic           any_pend,
  output logic [IDW-1:0] top_id
);
  logic [NCH-1:0] pend;
  logic [NCH-1:0] line_q;
  logic [LW-1:0]  best_lvl;
  logic           found;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= '0;
      line_q <= '0;
    end else begin
      line_q <= ch_irq;
      pend   <= (pend & ~clr_vec) | (ch_irq & ~line_q);
    end
  end

  always_comb begin
    found    = 1'b0;
    best_lvl = '0;
    top_id   = '0;
    for (int i = 0; i < NCH; i++) begin
      if (pend[i] && (!found || LEVELS[i*LW +: LW] > best_lvl)) begin
        found    = 1'b1;
        best_lvl = LEVELS[i*LW +: LW];
        top_id   = IDW'(i);
      end
    end
  end

  assign any_pend = found;
endmodule

// File: rtl/pwa_xfer.sv
module pwa_xfer
  import pwa_pkg::*;
#(
  parameter int DW = 32,
  parameter int NCH = 4,
  parameter int OFFW = 4,
  parameter int WR_CYC = 3,
  parameter int RD_CYC = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cpu_sel,
  input  logic            cpu_we,
  input  logic [OFFW-1:0] cpu_off,
  input  logic [DW-1:0]   cpu_wdata,
  input  logic [NCH-1:0]  hit,
  input  logic            stat_hit,
  input  logic [DW-1:0]   stat_word,
  input  logic [DW-1:0]   ib_rdata,
  output logic            cpu_ready,
  output logic [DW-1:0]   cpu_rdata,
  output logic [NCH-1:0]  ib_en,
  output logic            ib_we,
  output logic [OFFW-1:0] ib_addr,
  output logic [DW-1:0]   ib_wdata,
  output logic [NCH-1:0]  clr_vec
);
  localparam int MAXC = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int CW = $clog2(MAXC + 1);

  xfer_state_e   state;
  logic [CW-1:0] cnt;
  logic          last;

  assign last    = (state == XF_BUSY) && (cnt == '0);
  assign clr_vec = (last && !ib_we) ? ib_en : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= XF_IDLE;
      cnt       <= '0;
      cpu_ready <= 1'b0;
      cpu_rdata <= '0;
      ib_en     <= '0;
      ib_we     <= 1'b0;
      ib_addr   <= '0;
      ib_wdata  <= '0;
    end else begin
      cpu_ready <= 1'b0;
      unique case (state)
        XF_IDLE: begin
          if (cpu_sel) begin
            if (|hit) begin
              ib_en    <= hit;
              ib_we    <= cpu_we;
              ib_addr  <= cpu_off;
              ib_wdata <= cpu_wdata;
              cnt      <= cpu_we ? CW'(WR_CYC - 3) : CW'(RD_CYC - 3);
              state    <= XF_BUSY;
            end else begin
              cpu_ready <= 1'b1;
              cpu_rdata <= (stat_hit && !cpu_we) ? stat_word : '0;
              state     <= XF_DONE;
            end
          end
        end
        XF_BUSY: begin
          if (last) begin
            cpu_ready <= 1'b1;
            cpu_rdata <= ib_we ? '0 : ib_rdata;
            ib_en     <= '0;
            state     <= XF_DONE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= XF_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/proc_wrap_adapter.sv
module proc_wrap_adapter #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int NCH = 4,
  parameter int OFFW = 4,
  parameter logic [AW-1:0] CH_BASE = 16'h0100,
  parameter logic [AW-1:0] STAT_ADDR = 16'h0200,
  parameter int LW = 2,
  parameter logic [NCH*LW-1:0] LEVELS = 8'b11_00_11_01,
  parameter int WR_CYC = 3,
  parameter int RD_CYC = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cpu_sel,
  input  logic            cpu_we,
  input  logic [AW-1:0]   cpu_addr,
  input  logic [DW-1:0]   cpu_wdata,
  output logic [DW-1:0]   cpu_rdata,
  output logic            cpu_ready,
  output logic            cpu_irq,
  output logic [NCH-1:0]  ib_en,
  output logic            ib_we,
  output logic [OFFW-1:0] ib_addr,
  output logic [DW-1:0]   ib_wdata,
  input  logic [DW-1:0]   ib_rdata,
  input  logic [NCH-1:0]  ch_irq
);
  localparam int IDW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int PADW = DW - 1 - IDW;

  logic [NCH-1:0] hit;
  logic           stat_hit;
  logic [NCH-1:0] clr_vec;
  logic           any_pend;
  logic [IDW-1:0] top_id;
  logic [DW-1:0]  stat_word;

  assign stat_word = any_pend ? {1'b1, {PADW{1'b0}}, top_id} : '0;
  assign cpu_irq   = any_pend;

  pwa_decode #(
    .AW(AW), .NCH(NCH), .OFFW(OFFW), .CH_BASE(CH_BASE), .STAT_ADDR(STAT_ADDR)
  ) u_dec (
    .addr(cpu_addr), .hit(hit), .stat_hit(stat_hit)
  );

  pwa_irq #(
    .NCH(NCH), .LW(LW), .LEVELS(LEVELS), .IDW(IDW)
  ) u_irq (
    .clk(clk), .rst(rst), .ch_irq(ch_irq), .clr_vec(clr_vec),
    .any_pend(any_pend), .top_id(top_id)
  );

  pwa_xfer #(
    .DW(DW), .NCH(NCH), .OFFW(OFFW), .WR_CYC(WR_CYC), .RD_CYC(RD_CYC)
  ) u_xfer (
    .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
    .cpu_off(cpu_addr[OFFW-1:0]), .cpu_wdata(cpu_wdata), .hit(hit),
    .stat_hit(stat_hit), .stat_word(stat_word), .ib_rdata(ib_rdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .ib_en(ib_en),
    .ib_we(ib_we), .ib_addr(ib_addr), .ib_wdata(ib_wdata), .clr_vec(clr_vec)
  );
endmodule

// File: rtl/proc_wrap_adapter_chk.sv
module proc_wrap_adapter_chk #(
  parameter int NCH = 4,
  parameter int WR_CYC = 3,
  parameter int RD_CYC = 7
) (
  input logic           clk,
  input logic           rst,
  input logic           cpu_ready,
  input logic           cpu_irq,
  input logic [NCH-1:0] ib_en,
  input logic           ib_we,
  input logic [NCH-1:0] ch_irq
);
  logic [7:0] en_cnt;

  always_ff @(posedge clk) begin
    if (rst) en_cnt <= '0;
    else     en_cnt <= (|ib_en) ? en_cnt + 8'd1 : 8'd0;
  end

  assert_onehot_en_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ib_en));

  assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);

  assert_en_off_at_ready_R2: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> (ib_en == '0));

  assert_irq_on_edge_R7: assert property (@(posedge clk) disable iff (rst)
    (|(ch_irq & ~$past(ch_irq))) |=> cpu_irq);

  assert_write_len_R4: assert property (@(posedge clk) disable iff (rst)
    (cpu_ready && $past(|ib_en) && $past(ib_we)) |-> (en_cnt == 8'(WR_CYC - 2)));

  assert_read_len_R5: assert property (@(posedge clk) disable iff (rst)
    (cpu_ready && $past(|ib_en) && !$past(ib_we)) |-> (en_cnt == 8'(RD_CYC - 2)));
endmodule

bind proc_wrap_adapter proc_wrap_adapter_chk #(
  .NCH(NCH), .WR_CYC(WR_CYC), .RD_CYC(RD_CYC)
) u_chk (
  .clk(clk), .rst(rst), .cpu_ready(cpu_ready), .cpu_irq(cpu_irq),
  .ib_en(ib_en), .ib_we(ib_we), .ch_irq(ch_irq)
);

// File: tb/tb_proc_wrap_adapter.sv
module tb_proc_wrap_adapter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_sel = 1'b0;
  logic        cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_ready;
  logic        cpu_irq;
  logic [3:0]  ib_en;
  logic        ib_we;
  logic [3:0]  ib_addr;
  logic [31:0] ib_wdata;
  logic [31:0] ib_rdata;
  logic [3:0]  ch_irq = '0;

  always #2.5 clk = ~clk;

  proc_wrap_adapter dut (
    .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .cpu_irq(cpu_irq), .ib_en(ib_en), .ib_we(ib_we),
    .ib_addr(ib_addr), .ib_wdata(ib_wdata), .ib_rdata(ib_rdata), .ch_irq(ch_irq)
  );

  // channel adapter models
  logic [31:0] chan_mem [4];
  logic [31:0] ref_mem [4];
  always_ff @(posedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (rst) chan_mem[i] <= 32'hA000_0000 + 32'(i * 256);
      else if (ib_en[i] && ib_we) chan_mem[i] <= ib_wdata;
    end
  end
  always_comb begin
    ib_rdata = '0;
    for (int i = 0; i < 4; i++) if (ib_en[i]) ib_rdata = chan_mem[i] + 32'(ib_addr);
  end

  typedef struct {
    int          edges;
    bit          chk_data;
    logic [31:0] data;
    string       req;
  } exp_t;
  exp_t sb[$];

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // monitor: count edges while request held, compare on ready
  int edges = 0;
  initial begin
    forever begin
      @(posedge clk); #1;
      if (!rst && cpu_sel) edges++;
      if (!rst && cpu_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, "R10 unexpected ready", 32'(edges), 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(edges == e.edges, {e.req, " latency"}, 32'(edges), 32'(e.edges));
          if (e.chk_data) check(cpu_rdata == e.data, {e.req, " data"}, cpu_rdata, e.data);
        end
        edges = 0;
      end
    end
  end

  // driver: ch = channel expected to be enabled, -1 for none
  task automatic access(input bit we, input logic [15:0] addr, input logic [31:0] wd,
                        input int ch, input logic [31:0] exp, input bit chk,
                        input string req);
    exp_t e;
    @(negedge clk);
    e.edges = (ch < 0) ? 1 : (we ? 2 : 6);
    e.chk_data = chk;
    e.data = exp;
    e.req = req;
    sb.push_back(e);
    cpu_sel = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    @(posedge clk); #1;
    if (ch >= 0) begin
      check(ib_en == 4'(1 << ch), "R2/R3 one-hot enable", 32'(ib_en), 32'(1 << ch));
      check(ib_addr == addr[3:0], "R2 offset", 32'(ib_addr), 32'(addr[3:0]));
      if (we) begin
        check(ib_we && ib_wdata == wd, "R4 write lines", ib_wdata, wd);
        ref_mem[ch] = wd;
      end else begin
        check(!ib_we, "R5 read flag", 32'(ib_we), 32'd0);
      end
    end else begin
      check(ib_en == '0, "R6 no enable", 32'(ib_en), 32'd0);
    end
    while (!cpu_ready) begin @(posedge clk); #1; end
    @(negedge clk);
    cpu_sel = 1'b0;
    @(posedge clk); #1;
    check(!cpu_ready, "R10 ready one cycle", 32'(cpu_ready), 32'd0);
  endtask

  function automatic logic [31:0] stat_val(input bit v, input int id);
    return v ? {1'b1, 29'd0, 2'(id)} : 32'd0;
  endfunction

  task automatic pulse(input logic [3:0] m);
    @(negedge clk); ch_irq = ch_irq | m;
    @(negedge clk); ch_irq = ch_irq & ~m;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4; i++) ref_mem[i] = 32'hA000_0000 + 32'(i * 256);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!cpu_ready && !cpu_irq && ib_en == '0 && cpu_rdata == '0, "R1 in reset",
          {cpu_ready, cpu_irq, ib_en, 26'd0}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(!cpu_ready && !cpu_irq && ib_en == '0 && cpu_rdata == '0, "R1 after reset",
          {cpu_ready, cpu_irq, ib_en, 26'd0}, 32'd0);

    access(1, 16'h0103, 32'h1122_3344, 0, '0, 0, "R4 write ch0");
    access(0, 16'h0103, '0, 0, 32'h1122_3344 + 32'd3, 1, "R5 read ch0");
    access(1, 16'h012F, 32'hCAFE_0001, 2, '0, 0, "R4 write ch2 top offset");
    access(0, 16'h0120, '0, 2, 32'hCAFE_0001, 1, "R5 read ch2");
    access(0, 16'h0137, '0, 3, ref_mem[3] + 32'd7, 1, "R2 read ch3");
    access(0, 16'h0000, '0, -1, 32'd0, 1, "R6 miss low");
    access(0, 16'h00FF, '0, -1, 32'd0, 1, "R6 miss below base");
    access(1, 16'h0140, 32'hDEAD_BEEF, -1, '0, 0, "R6 miss write above");
    access(0, 16'h0140, '0, -1, 32'd0, 1, "R6 miss read above");
    access(0, 16'h0200, '0, -1, stat_val(0, 0), 1, "R8 status empty");

    pulse(4'b0101);
    @(negedge clk);
    check(cpu_irq, "R7 irq raised", 32'(cpu_irq), 32'd1);
    access(0, 16'h0200, '0, -1, stat_val(1, 0), 1, "R8 status ch0 over ch2");
    pulse(4'b1000);
    access(0, 16'h0200, '0, -1, stat_val(1, 3), 1, "R8 status ch3");
    @(negedge clk); ch_irq[1] = 1'b1;
    access(0, 16'h0200, '0, -1, stat_val(1, 1), 1, "R8 tie to lower index");
    access(0, 16'h0115, '0, 1, ref_mem[1] + 32'd5, 1, "R9 read ch1");
    access(0, 16'h0200, '0, -1, stat_val(1, 3), 1, "R9/R7 held line no reset");
    @(negedge clk); ch_irq[1] = 1'b0;
    access(1, 16'h0131, 32'h0000_0033, 3, '0, 0, "R4 write ch3");
    access(0, 16'h0200, '0, -1, stat_val(1, 3), 1, "R9 write keeps pending");
    access(0, 16'h0131, '0, 3, 32'h0000_0034, 1, "R9 read ch3");
    access(0, 16'h0200, '0, -1, stat_val(1, 0), 1, "R9 next ch0");
    access(0, 16'h0100, '0, 0, 32'h1122_3344, 1, "R9 read ch0");
    access(0, 16'h0200, '0, -1, stat_val(1, 2), 1, "R9 next ch2");
    access(0, 16'h0122, '0, 2, 32'hCAFE_0003, 1, "R9 read ch2");
    access(0, 16'h0200, '0, -1, stat_val(0, 0), 1, "R8 status cleared");
    check(!cpu_irq, "R7 irq drops", 32'(cpu_irq), 32'd0);

    repeat (3) @(posedge clk);
    check(sb.size() == 0, "R10 all accesses done", 32'(sb.size()), 32'd0);
    finish_run();
  end
endmodule